// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds the running time and date as eight BCD register bytes: seconds, minutes, hours, date, month, year, day of week and century. A prescaler outside the block supplies a one-cycle tick once per second. On each tick the seconds advance, and any carry ripples through minutes, hours, date, month, year and century in the same clock cycle. The hour byte carries its own mode bit, so one register selects either 24-hour counting or 12-hour counting with a PM flag. Month lengths and a simple divisible-by-four leap rule are built in.

A bus-side controller sets the time through a load port. A byte mask picks which registers take new values in a cycle, and the others keep their contents. All eight registers are always visible on a flat read bus. Reset stands for power-up after both supplies have failed. It sets a run-inhibit flag that freezes the count until the controller loads at least one register. This keeps a clock whose time is known to be lost from running on as though it were valid.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds (read byte 0) and minutes (byte 1) count in BCD from 00 to 59. A tick advances seconds by one. Seconds 59 wraps to 00 and advances minutes. Minutes 59 wraps to 00 and advances the hour. With no tick and no load, no register changes.
- R2: When hour bit 7 is 1, the hour byte (byte 2) counts bits 5:0 in BCD from 00 to 23. Hour 23 wraps to 00, advances the date and keeps bits 7:6.
- R3: When hour bit 7 is 0, bits 4:0 count 01 to 12 in BCD and bit 5 is PM (1 = PM). Hour 11 steps to 12 and toggles PM. Hour 12 steps to 01 and keeps PM. Stepping from 11 PM to 12 AM advances the date.
- R4: The date (byte 3) counts from 01 up to the length of the current month. Months 01, 03, 05, 07, 08, 10 and 12 have 31 days; months 04, 06, 09 and 11 have 30. February (02) has 28 days, or 29 in a leap year. The last date wraps to 01 and advances the month (byte 4). Month 12 wraps to 01 and advances the year (byte 5), which counts 00 to 99 in BCD.
- R5: A year whose value is divisible by 4, including 00, is a leap year. No correction for centuries is applied.
- R6: When the year wraps from 99 to 00, a century byte (byte 7) of 0x19 becomes 0x20. A century of 0x20 stays 0x20.
- R7: The day of week (byte 6, bits 2:0, upper bits read 0 after counting) advances once each time the date advances, in the order 0,1,2,3,4,5,6,0.
- R8: After reset the registers read century 0x20, day 0, year 0x00, month 0x01, date 0x01, hour 0x80 (24-hour mode, 00), minutes 0x00 and seconds 0x00, and inhibit_o is 1. While inhibited, ticks change nothing.
- R9: In a cycle where ld_mask_i bit k is 1, register k takes ld_data_i byte k unchanged, and registers whose mask bit is 0 hold. Any load clears the inhibit flag. A tick in the same cycle as a load is ignored. The next tick advances from the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low (power-up after total loss) |
| tick_i | input | 1 | One-cycle pulse, once per second |
| ld_mask_i | input | 8 | Per-register load enable, bit k selects byte k |
| ld_data_i | input | 64 | Load data, byte k goes to register k |
| rd_data_o | output | 64 | All registers, byte k is register k |
| inhibit_o | output | 1 | Count is frozen until the first load |

## Verification
Every register is visible on the read bus in the cycle after the edge that updates it. A wrong carry or a bad month length therefore shows up as a wrong byte straight after the tick that crosses the boundary, not many seconds later. The vectors load a state just before each rollover: seconds, minutes, both hour modes, every class of month length, leap and non-leap February, and both century cases. Each vector then applies one tick and compares the whole 64-bit bus. Directed cases cover the frozen state after reset, a partial load, and a load that coincides with a tick, where a count that is lost or doubled would show as an off-by-one in the seconds byte.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned BUS_W    = REG_W * NUM_REGS;

  localparam int unsigned IDX_SEC = 0;
  localparam int unsigned IDX_MIN = 1;
  localparam int unsigned IDX_HR  = 2;
  localparam int unsigned IDX_DT  = 3;
  localparam int unsigned IDX_MO  = 4;
  localparam int unsigned IDX_YR  = 5;
  localparam int unsigned IDX_DOW = 6;
  localparam int unsigned IDX_CEN = 7;

  localparam logic [BUS_W-1:0] RESET_VAL = 64'h2000_0001_0180_0000;

  function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // year value divisible by 4: (10*t + o) mod 4 == (2*t + o) mod 4
  function automatic logic is_leap(input logic [REG_W-1:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [REG_W-1:0] month_len(input logic [REG_W-1:0] mo,
                                                 input logic leap);
    case (mo)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MIN_V = '0
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] max_i,
  input  logic         en_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  import rtc_pkg::*;

  // out-of-range loaded values wrap as well
  assign wrap_o = en_i && (val_i >= max_i);

  always_comb begin
    if (!en_i)       nxt_o = val_i;
    else if (wrap_o) nxt_o = MIN_V;
    else             nxt_o = bcd_inc(val_i);
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
  input  logic [7:0] hour_i,
  input  logic       en_i,
  output logic [7:0] nxt_o,
  output logic       day_o
);
  import rtc_pkg::*;

  logic       mode24;
  logic       pm;
  logic [7:0] inc_v;

  assign mode24 = hour_i[7];
  assign pm     = hour_i[5];

  always_comb begin
    nxt_o = hour_i;
    day_o = 1'b0;
    inc_v = '0;
    if (en_i) begin
      if (mode24) begin
        inc_v = bcd_inc({2'b00, hour_i[5:0]});
        if (hour_i[5:0] >= 6'h23) begin
          nxt_o = {hour_i[7:6], 6'h00};
          day_o = 1'b1;
        end else begin
          nxt_o = {hour_i[7:6], inc_v[5:0]};
        end
      end else begin
        inc_v = bcd_inc({3'b000, hour_i[4:0]});
        if (hour_i[4:0] >= 5'h12) begin
          nxt_o = {hour_i[7:5], 5'h01};
        end else if (hour_i[4:0] == 5'h11) begin
          nxt_o = {hour_i[7:6], ~pm, 5'h12};
          day_o = pm;
        end else begin
          nxt_o = {hour_i[7:5], inc_v[4:0]};
        end
      end
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [NUM_REGS-1:0] ld_mask_i,
  input  logic [BUS_W-1:0]    ld_data_i,
  output logic [BUS_W-1:0]    rd_data_o,
  output logic                inhibit_o
);
  logic [NUM_REGS-1:0][REG_W-1:0] regs_q, regs_d, adv_v;
  logic                           inhibit_q;
  logic                           ld_any, adv;
  logic                           sec_wrap, min_wrap, day_carry, dt_wrap, mo_wrap, yr_wrap;
  logic [REG_W-1:0]               dt_max;

  assign ld_any = |ld_mask_i;
  assign adv    = tick_i && !inhibit_q && !ld_any;
  assign dt_max = month_len(regs_q[IDX_MO], is_leap(regs_q[IDX_YR]));

  rtc_bcd_wrap #(.W(REG_W), .MIN_V(8'h00)) i_sec (
    .val_i(regs_q[IDX_SEC]), .max_i(8'h59), .en_i(adv),
    .nxt_o(adv_v[IDX_SEC]), .wrap_o(sec_wrap));

  rtc_bcd_wrap #(.W(REG_W), .MIN_V(8'h00)) i_min (
    .val_i(regs_q[IDX_MIN]), .max_i(8'h59), .en_i(sec_wrap),
    .nxt_o(adv_v[IDX_MIN]), .wrap_o(min_wrap));

  rtc_hour_step i_hour (
    .hour_i(regs_q[IDX_HR]), .en_i(min_wrap),
    .nxt_o(adv_v[IDX_HR]), .day_o(day_carry));

  rtc_bcd_wrap #(.W(REG_W), .MIN_V(8'h01)) i_date (
    .val_i(regs_q[IDX_DT]), .max_i(dt_max), .en_i(day_carry),
    .nxt_o(adv_v[IDX_DT]), .wrap_o(dt_wrap));

  rtc_bcd_wrap #(.W(REG_W), .MIN_V(8'h01)) i_month (
    .val_i(regs_q[IDX_MO]), .max_i(8'h12), .en_i(dt_wrap),
    .nxt_o(adv_v[IDX_MO]), .wrap_o(mo_wrap));

  rtc_bcd_wrap #(.W(REG_W), .MIN_V(8'h00)) i_year (
    .val_i(regs_q[IDX_YR]), .max_i(8'h99), .en_i(mo_wrap),
    .nxt_o(adv_v[IDX_YR]), .wrap_o(yr_wrap));

  always_comb begin
    adv_v[IDX_DOW] = regs_q[IDX_DOW];
    if (day_carry)
      adv_v[IDX_DOW] = (regs_q[IDX_DOW][2:0] >= 3'd6) ? 8'h00
                     : {5'b0, regs_q[IDX_DOW][2:0] + 3'd1};
    adv_v[IDX_CEN] = regs_q[IDX_CEN];
    if (yr_wrap && regs_q[IDX_CEN] == 8'h19) adv_v[IDX_CEN] = 8'h20;
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_ld
    assign regs_d[k] = ld_mask_i[k] ? ld_data_i[k*REG_W +: REG_W] : adv_v[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q    <= RESET_VAL;
      inhibit_q <= 1'b1;
    end else begin
      regs_q <= regs_d;
      if (ld_any) inhibit_q <= 1'b0;
    end
  end

  assign rd_data_o = regs_q;
  assign inhibit_o = inhibit_q;

  p_idle_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !ld_any |=> $stable(regs_q));

  p_sec_no_carry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !ld_any && regs_q[IDX_SEC] < 8'h59 |=> $stable(regs_q[IDX_MIN]));

  p_century_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[IDX_CEN] == 8'h20 && !ld_mask_i[IDX_CEN] |=> regs_q[IDX_CEN] == 8'h20);

  p_hold_inhibit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_q && !ld_any |=> $stable(regs_q));

  p_load_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_any |=> !inhibit_q);

  p_load_sec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_mask_i[IDX_SEC] |=> regs_q[IDX_SEC] == $past(ld_data_i[REG_W-1:0]));
endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  ld_mask = '0;
  logic [63:0] ld_data = '0;
  logic [63:0] rd;
  logic        inh;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rtc_calendar_core i_rtc_calendar_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .ld_mask_i(ld_mask), .ld_data_i(ld_data),
    .rd_data_o(rd), .inhibit_o(inh));

  // byte order {cen, dow, yr, mo, dt, hr, mn, sc}; {start, expected after one tick}
  localparam int NV = 23;
  localparam logic [127:0] VEC [NV] = '{
    {64'h2003_2405_1092_3417, 64'h2003_2405_1092_3418},  // R1
    {64'h2003_2405_1092_3459, 64'h2003_2405_1092_3500},  // R1
    {64'h2003_2405_1089_5959, 64'h2003_2405_1090_0000},  // R1 R2
    {64'h2003_2405_10A3_5959, 64'h2004_2405_1180_0000},  // R2 R7
    {64'h2006_2404_30A3_5959, 64'h2000_2405_0180_0000},  // R4 R7
    {64'h2001_2405_1011_5959, 64'h2001_2405_1032_0000},  // R3
    {64'h2001_2405_1032_5959, 64'h2001_2405_1021_0000},  // R3
    {64'h2001_2405_1031_5959, 64'h2002_2405_1112_0000},  // R3
    {64'h2001_2405_1012_5959, 64'h2001_2405_1001_0000},  // R3
    {64'h2002_2402_28A3_5959, 64'h2003_2402_2980_0000},  // R5
    {64'h2002_2302_28A3_5959, 64'h2003_2303_0180_0000},  // R5
    {64'h2002_2402_29A3_5959, 64'h2003_2403_0180_0000},  // R4
    {64'h2002_0002_28A3_5959, 64'h2003_0002_2980_0000},  // R5
    {64'h2002_1202_28A3_5959, 64'h2003_1202_2980_0000},  // R5
    {64'h1905_9912_31A3_5959, 64'h2006_0001_0180_0000},  // R6
    {64'h2004_9912_31A3_5959, 64'h2005_0001_0180_0000},  // R6
    {64'h2004_2312_31A3_5959, 64'h2005_2401_0180_0000},  // R4
    {64'h2000_2401_31A3_5959, 64'h2001_2402_0180_0000},  // R4
    {64'h2000_2409_30A3_5959, 64'h2001_2410_0180_0000},  // R4
    {64'h2000_2407_09A3_5959, 64'h2001_2407_1080_0000},  // R4
    {64'h2000_2407_30A3_5959, 64'h2001_2407_3180_0000},  // R4
    {64'h2000_2407_1599_5959, 64'h2000_2407_15A0_0000},  // R2
    {64'h2000_2407_1509_5959, 64'h2000_2407_1510_0000}   // R3
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] m, input logic [63:0] d, input logic t);
    @(negedge clk);
    ld_mask = m; ld_data = d; tick = t;
    @(negedge clk);
    ld_mask = '0; tick = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset regs", rd, 64'h2000_0001_0180_0000);
    check("R8 reset inhibit", {63'b0, inh}, 64'd1);
    rst_n = 1'b1;
    do_tick();
    do_tick();
    check("R8 tick while inhibited", rd, 64'h2000_0001_0180_0000);

    do_load(8'h01, 64'h0000_0000_0000_0042, 1'b0);
    check("R9 partial load", rd, 64'h2000_0001_0180_0042);
    check("R9 inhibit cleared", {63'b0, inh}, 64'd0);

    do_tick();
    check("R1 single tick", rd, 64'h2000_0001_0180_0043);

    do_load(8'h02, 64'h0000_0000_0000_0700, 1'b1);
    check("R9 tick during load ignored", rd, 64'h2000_0001_0180_0743);

    repeat (4) @(negedge clk);
    check("R1 idle hold", rd, 64'h2000_0001_0180_0743);

    do_tick();
    check("R9 advance after load", rd, 64'h2000_0001_0180_0744);

    for (int i = 0; i < NV; i++) begin
      do_load(8'hFF, VEC[i][127:64], 1'b0);
      check($sformatf("R9 load vector %0d", i), rd, VEC[i][127:64]);
      do_tick();
      check($sformatf("R1-chain vector %0d", i), rd, VEC[i][63:0]);
    end

    finish_run();
  end
endmodule